// File: doc/BRIEF.md
# Strobe-Driven Four-Plane DRAM Emulator

This block puts an on-chip synchronous RAM behind the pin-level interface of four 1-bit dynamic RAM chips wired side by side. A controller built for those chips drives a multiplexed address bus, an active-low row strobe, an active-low column strobe and an active-low write enable. It can keep its timing logic unchanged. Each access moves one nibble, one bit per plane, and the controller builds a byte from two such accesses. The physical chips had no clock. This block adds one fast clock, which samples the strobes and runs the internal RAM.

Both strobes pass through two-flop synchronizers, and their falling edges are then detected on the fast clock. A falling row strobe captures the bus as the row half of the location. A falling column strobe, seen while the row strobe is low, captures the bus as the column half. It then starts a write or a read, depending on write enable. A falling column strobe while the row strobe is still high is a refresh and touches nothing. The default depth is small (`MUX_W` = 5, so 1024 locations per plane). Setting `MUX_W` to 8 gives the full 64K-per-plane geometry.

Top module: `dram_emu`

## Requirements
- R1: After synchronous reset, all four `dout` lines are 0.
- R2: The stored location is `{row, column}`. The row comes from `addr` at the synchronized row-strobe fall, and the column from `addr` at the synchronized column-strobe fall. Data bit i (`din[i]`, `dout[i]`) belongs to plane i, and the planes share one address.
- R3: If `we_n` is 0 at the synchronized column-strobe fall while the row strobe is low, `din` is stored at the addressed location in all four planes.
- R4: In a read cycle (`we_n` is 1 at the column fall, row strobe low), `dout` shows the stored nibble no later than the third rising clock edge after `cas_n` is first sampled low. It holds that value while `cas_n` stays low.
- R5: `dout` returns to 0 no later than the third rising clock edge after `cas_n` is first sampled high.
- R6: A write cycle drives no data: `dout` stays 0 throughout it.
- R7: A column-strobe fall while the synchronized row strobe is high is a refresh. It changes no stored data and `dout` stays 0.
- R8: Locations that differ only in the row, or only in the column, are independent. Two nibble writes at neighbouring columns are read back as separate halves of a byte.
- R9: Each column-strobe fall starts at most one memory operation, either a read or a write, never both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, at least four times the strobe toggle rate |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | MUX_W | Multiplexed row/column address bus |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at the column fall |
| din | input | 4 | Write data, one bit per plane |
| dout | output | 4 | Read data, one bit per plane, 0 when no read is being held |

## Verification
The assertions assume that each strobe level lasts at least four clock cycles. They also assume that the column strobe never falls within two cycles of the row strobe falling, and that `addr`, `we_n` and `din` are steady from the column fall through the sampling delay. The bench changes inputs only on falling clock edges and holds every strobe phase for four cycles. It moves the bus to the column value together with the column fall, keeps the bus steady until the strobe rises, and runs the refresh case with the column strobe low before the row strobe falls.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

    localparam int NUM_PLANES = 4;
    localparam int DEF_MUX_W  = 5;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_READ    = 2'd1,
        CYC_WRITE   = 2'd2,
        CYC_REFRESH = 2'd3
    } cycle_e;

    // Strobe index inside the synchronizer array
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int NUM_STB = 2;

    function automatic cycle_e classify(input logic col_fall,
                                        input logic row_high,
                                        input logic we_low);
        cycle_e k;
        if (!col_fall)     k = CYC_IDLE;
        else if (row_high) k = CYC_REFRESH;
        else if (we_low)   k = CYC_WRITE;
        else               k = CYC_READ;
        return k;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], strobe_n};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/access_ctrl.sv
module access_ctrl
    import dram_emu_pkg::*;
#(
    parameter int MUX_W = DEF_MUX_W,
    parameter int NP    = NUM_PLANES,
    localparam int LOC_W = 2 * MUX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_fall,
    input  logic             ras_lvl,
    input  logic             cas_fall,
    input  logic             cas_lvl,
    input  logic [MUX_W-1:0] addr,
    input  logic             we_n,
    input  logic [NP-1:0]    din,
    output logic [LOC_W-1:0] loc,
    output logic             wr_en,
    output logic             rd_en,
    output logic [NP-1:0]    wdata,
    output logic             out_valid
);
    logic [MUX_W-1:0] row_q;
    cycle_e           kind;

    always_ff @(posedge clk) begin
        if (rst) row_q <= '0;
        else if (ras_fall) row_q <= addr;
    end

    always_comb begin
        kind  = classify(cas_fall, ras_lvl, ~we_n);
        wr_en = (kind == CYC_WRITE);
        rd_en = (kind == CYC_READ);
        loc   = {row_q, addr};
        wdata = din;
    end

    // Holds read data on the pins until the column strobe goes high again
    always_ff @(posedge clk) begin
        if (rst)                  out_valid <= 1'b0;
        else if (rd_en)           out_valid <= 1'b1;
        else if (cas_lvl || wr_en) out_valid <= 1'b0;
    end
endmodule

// File: rtl/bit_plane.sv
module bit_plane #(
    parameter int AW = 10,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a,
    input  logic          we,
    input  logic          d,
    input  logic          re,
    output logic          q
);
    logic mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[a] <= d;
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (re) q <= mem[a];
    end
endmodule

// File: rtl/dram_emu.sv
module dram_emu
    import dram_emu_pkg::*;
#(
    parameter int MUX_W = DEF_MUX_W,
    localparam int NP    = NUM_PLANES,
    localparam int LOC_W = 2 * MUX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MUX_W-1:0] addr,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [NP-1:0]    din,
    output logic [NP-1:0]    dout
);
    logic [NUM_STB-1:0] stb_in;
    logic [NUM_STB-1:0] stb_lvl;
    logic [NUM_STB-1:0] stb_fall;

    logic [LOC_W-1:0] loc;
    logic             wr_en;
    logic             rd_en;
    logic [NP-1:0]    wdata;
    logic [NP-1:0]    q_all;
    logic             out_valid;
    logic             ras_lvl;

    assign stb_in[STB_RAS] = ras_n;
    assign stb_in[STB_CAS] = cas_n;
    assign ras_lvl         = stb_lvl[STB_RAS];

    for (genvar s = 0; s < NUM_STB; s++) begin : g_sync
        strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .strobe_n (stb_in[s]),
            .level    (stb_lvl[s]),
            .fall     (stb_fall[s])
        );
    end

    access_ctrl #(.MUX_W(MUX_W), .NP(NP)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ras_fall  (stb_fall[STB_RAS]),
        .ras_lvl   (ras_lvl),
        .cas_fall  (stb_fall[STB_CAS]),
        .cas_lvl   (stb_lvl[STB_CAS]),
        .addr      (addr),
        .we_n      (we_n),
        .din       (din),
        .loc       (loc),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .out_valid (out_valid)
    );

    for (genvar p = 0; p < NP; p++) begin : g_plane
        bit_plane #(.AW(LOC_W)) u_plane (
            .clk (clk),
            .rst (rst),
            .a   (loc),
            .we  (wr_en),
            .d   (wdata[p]),
            .re  (rd_en),
            .q   (q_all[p])
        );
    end

    assign dout = out_valid ? q_all : '0;
endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cas_n,
    input logic          ras_lvl,
    input logic          wr_en,
    input logic          rd_en,
    input logic [NP-1:0] q_all,
    input logic [NP-1:0] dout
);
    logic [1:0] cas_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                    cas_hi_cnt <= '0;
        else if (!cas_n)            cas_hi_cnt <= '0;
        else if (cas_hi_cnt != 2'd3) cas_hi_cnt <= cas_hi_cnt + 2'd1;
    end

    a_r9_one_op: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, rd_en}));

    a_r7_write_needs_row: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ras_lvl);

    a_r4_read_drives_q: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (dout == q_all));

    a_r6_write_quiet: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (dout == '0));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (cas_hi_cnt == 2'd3) |-> (dout == '0));
endmodule

bind dram_emu dram_emu_chk #(.NP(NP)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cas_n   (cas_n),
    .ras_lvl (ras_lvl),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .q_all   (q_all),
    .dout    (dout)
);

// File: tb/tb_dram_emu.sv
module tb_dram_emu;
    localparam int MUX_W = 5;
    localparam int HOLD  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [MUX_W-1:0] addr = '0;
    logic             ras_n = 1'b1;
    logic             cas_n = 1'b1;
    logic             we_n = 1'b1;
    logic [3:0]       din = '0;
    logic [3:0]       dout;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dram_emu #(.MUX_W(MUX_W)) dut (
        .clk(clk), .rst(rst), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .din(din), .dout(dout)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_nib(input logic [MUX_W-1:0] row, input logic [MUX_W-1:0] col,
                             input logic [3:0] nib);
        @(negedge clk);
        addr = row; ras_n = 1'b0;
        wait_cyc(HOLD);
        addr = col; we_n = 1'b0; din = nib; cas_n = 1'b0;
        wait_cyc(3);
        check("R6 write drives no data", dout, 4'b0000);
        wait_cyc(HOLD - 3);
        cas_n = 1'b1; we_n = 1'b1;
        wait_cyc(HOLD);
        ras_n = 1'b1;
        wait_cyc(HOLD);
    endtask

    task automatic read_nib(input string req, input logic [MUX_W-1:0] row,
                            input logic [MUX_W-1:0] col, input logic [3:0] exp);
        @(negedge clk);
        addr = row; ras_n = 1'b0;
        wait_cyc(HOLD);
        addr = col; cas_n = 1'b0;
        wait_cyc(3);
        check({req, " R4 read by third edge"}, dout, exp);
        wait_cyc(3);
        check({req, " R4 read held"}, dout, exp);
        cas_n = 1'b1;
        wait_cyc(3);
        check("R5 zero after column rise", dout, 4'b0000);
        ras_n = 1'b1;
        wait_cyc(HOLD);
    endtask

    task automatic t_reset;
        wait_cyc(3);
        check("R1 reset output", dout, 4'b0000);
    endtask

    task automatic t_plane_bits;
        write_nib(5'd1, 5'd0, 4'b0001);
        write_nib(5'd1, 5'd1, 4'b0010);
        write_nib(5'd1, 5'd2, 4'b0100);
        write_nib(5'd1, 5'd3, 4'b1000);
        read_nib("R2 plane0", 5'd1, 5'd0, 4'b0001);
        read_nib("R2 plane1", 5'd1, 5'd1, 4'b0010);
        read_nib("R2 plane2", 5'd1, 5'd2, 4'b0100);
        read_nib("R2 plane3", 5'd1, 5'd3, 4'b1000);
    endtask

    task automatic t_overwrite;
        write_nib(5'd7, 5'd9, 4'b1010);
        read_nib("R3 first", 5'd7, 5'd9, 4'b1010);
        write_nib(5'd7, 5'd9, 4'b0101);
        read_nib("R3 overwrite", 5'd7, 5'd9, 4'b0101);
    endtask

    task automatic t_byte_and_rows;
        write_nib(5'd20, 5'd4, 4'hC);
        write_nib(5'd20, 5'd5, 4'h3);
        write_nib(5'd21, 5'd4, 4'h6);
        write_nib(5'd31, 5'd31, 4'hF);
        read_nib("R8 byte low", 5'd20, 5'd4, 4'hC);
        read_nib("R8 byte high", 5'd20, 5'd5, 4'h3);
        read_nib("R8 other row", 5'd21, 5'd4, 4'h6);
        read_nib("R8 top corner", 5'd31, 5'd31, 4'hF);
    endtask

    task automatic t_refresh;
        @(negedge clk);
        addr = 5'd4; we_n = 1'b0; din = 4'h0; cas_n = 1'b0;
        wait_cyc(HOLD);
        check("R7 refresh output", dout, 4'b0000);
        addr = 5'd20; ras_n = 1'b0;
        wait_cyc(HOLD);
        check("R7 refresh with row low", dout, 4'b0000);
        ras_n = 1'b1;
        wait_cyc(HOLD);
        cas_n = 1'b1; we_n = 1'b1;
        wait_cyc(HOLD);
        read_nib("R7 data kept", 5'd20, 5'd4, 4'hC);
    endtask

    task automatic t_back_to_back;
        write_nib(5'd2, 5'd17, 4'h9);
        read_nib("R9 read after write", 5'd2, 5'd17, 4'h9);
        read_nib("R9 repeat read", 5'd2, 5'd17, 4'h9);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plane_bits();
        t_overwrite();
        t_byte_and_rows();
        t_refresh();
        t_back_to_back();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule